// File: doc/BRIEF.md
# Cascadable Content-Addressable Memory Slice

This block is one slice of a content-addressable memory (CAM) built to be stacked vertically with identical slices. Each slice holds a parameterized number of key entries, each with a valid bit. Every slice compares its own entries against a key at once. The slice with the highest-priority match in the whole stack then answers on the shared read bus. Priority goes to earlier slices in the chain, and to lower indices inside a slice. The answer is a system match address: the slice's page number in the upper bits and the local entry index in the lower bits.

Two active-low flag chains tie the slices together without external logic. The match chain tells each slice whether any earlier slice matched. The full chain tells each slice whether every earlier slice is full. With these chains, only the winning slice drives the bus, and a write to the next free location lands in the first slice that still has room. A page register and a device-select register let software address one slice, or all slices when the select value is all ones. Every operation runs on a single clock. Compare results and read data are registered one cycle after the command, and the chain outputs are combinational.

Top module: `cam_slice`

## Requirements
- R1: While reset is held and on the first edge after it, ma_n and mm_n are 1 and rd_oe is 0. After reset no entry is valid, so mf_n equals match_in_n and ff_n is 1.
- R2: One cycle after a compare (op 3), ma_n is 0 exactly when at least one valid entry equals cmd_data. mm_n is 0 exactly when at least two valid entries do. Both flags hold until the next compare or invalidate.
- R3: A status read (op 6, cmd_idx[1:0]=0) while match_in_n is 1 and ma_n is 0 sets rd_oe to 1 on the next cycle. rd_data then carries the page register in bits [IDX_W+PAGE_W-1:IDX_W] and the lowest matching index in bits [IDX_W-1:0], with the other bits 0. rd_oe is 0 in any cycle that does not follow a granted read, and rd_data is 0 whenever rd_oe is 0.
- R4: A status read or an entry read is refused (rd_oe stays 0) when match_in_n is 0 or the slice holds no match.
- R5: mf_n is 0 when match_in_n is 0 or ma_n is 0, and is 1 otherwise.
- R6: Local full means every entry is valid. ff_n is 0 exactly when full_in_n is 0 and the slice is locally full.
- R7: A next-free write (op 5) stores cmd_data in the lowest-indexed invalid entry only when full_in_n is 0 and the slice is not full. Otherwise it has no effect.
- R8: A next-free read (op 6, cmd_idx[1:0]=1) is granted whenever full_in_n is 0 and the slice is not full, even with no match. It returns the page in the upper field and the lowest invalid index in the lower field, as in R3.
- R9: A select write (op 1) loads cmd_data[PAGE_W-1:0] into the device select register in every slice. A page write (op 2) and an indexed entry write (op 4, entry cmd_idx) are accepted only when device select equals the page register or is all ones.
- R10: An entry read (op 6, cmd_idx[1:0]=2) under the grant conditions of R3 returns the stored key at the highest-priority match index.
- R11: An invalidate (op 7) under the grant conditions of R3 clears the valid bit of the highest-priority match entry and returns ma_n and mm_n to 1. A slice that is not the winner ignores it.
- R12: Reset sets the page register to 0 and device select to all ones, so the first page write and entry write reach every slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code (0 none, 1 select, 2 page, 3 compare, 4 indexed write, 5 next-free write, 6 read, 7 invalidate) |
| cmd_idx | input | IDX_W | Entry index for op 4; read kind in bits [1:0] for op 6 |
| cmd_data | input | DATA_W | Key, write data or register value |
| match_in_n | input | 1 | Low when an earlier slice matched (tie high on the first slice) |
| full_in_n | input | 1 | Low when all earlier slices are full (tie low on the first slice) |
| rd_data | output | DATA_W | Registered read data, 0 when not driving |
| rd_oe | output | 1 | This slice drives the shared read bus |
| ma_n | output | 1 | Local match, active low |
| mm_n | output | 1 | Local multiple match, active low |
| mf_n | output | 1 | System match up to this slice, active low |
| ff_n | output | 1 | System full up to this slice, active low |

## Verification
A directed sequence covers the cases below:
- a single match, which shows the index is reported together with the page;
- two matching entries, which separate lowest-index priority from a plain hit and raise the multiple-match flag;
- the same reads with the match-in chain asserted, which show that an earlier slice's match keeps this slice off the bus;
- a key that misses, which shows that next-free reads still go through while status and entry reads are refused.

Filling the slice with next-free writes, while full_in_n is switched, separates local fullness from chain fullness and shows that writes into a full slice are dropped. Changing device select away from the page shows which writes are targeted and which are broadcast. A long run of random commands over a small key set, with random chain inputs, exercises the overlap between invalidates, compares and writes.

// File: rtl/cam_pkg.sv
package cam_pkg;
   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_DSEL   = 3'd1,
      OP_PAGE   = 3'd2,
      OP_CMP    = 3'd3,
      OP_WRIDX  = 3'd4,
      OP_WRFREE = 3'd5,
      OP_READ   = 3'd6,
      OP_INVAL  = 3'd7
   } cam_op_e;

   localparam logic [1:0] RK_STATUS = 2'd0;
   localparam logic [1:0] RK_FREE   = 2'd1;
   localparam logic [1:0] RK_ENTRY  = 2'd2;
endpackage

// File: rtl/cam_store.sv
module cam_store #(
   parameter int ENTRIES = 16,
   parameter int KEY_W   = 32,
   parameter int IDX_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [KEY_W-1:0]   wr_key,
   input  logic               clr_en,
   input  logic [IDX_W-1:0]   clr_idx,
   input  logic [KEY_W-1:0]   key,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [KEY_W-1:0]   rd_key,
   output logic [ENTRIES-1:0] vld,
   output logic [ENTRIES-1:0] hit
);
   logic [ENTRIES-1:0][KEY_W-1:0] mem;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld <= '0;
         mem <= '0;
      end else begin
         for (int e = 0; e < ENTRIES; e++) begin
            if (wr_en && wr_idx == IDX_W'(e)) begin
               vld[e] <= 1'b1;
               mem[e] <= wr_key;
            end else if (clr_en && clr_idx == IDX_W'(e)) begin
               vld[e] <= 1'b0;
            end
         end
      end
   end

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit[g] = vld[g] && (mem[g] == key);
   end

   assign rd_key = mem[rd_idx];
endmodule

// File: rtl/cam_prio.sv
module cam_prio #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     vec,
   output logic             any,
   output logic             multi,
   output logic [IDX_W-1:0] first
);
   always_comb begin
      first = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) first = IDX_W'(i);
      end
   end

   assign any   = |vec;
   assign multi = |(vec & (vec - N'(1)));
endmodule

// File: rtl/cam_slice.sv
module cam_slice
   import cam_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int KEY_W   = 32,
   parameter int DATA_W  = 32,
   parameter int PAGE_W  = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [IDX_W-1:0]  cmd_idx,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic              match_in_n,
   input  logic              full_in_n,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_oe,
   output logic              ma_n,
   output logic              mm_n,
   output logic              mf_n,
   output logic              ff_n
);
   if (ENTRIES < 4) begin : g_chk_depth
      $error("cam_slice: ENTRIES must be at least 4");
   end
   if (KEY_W > DATA_W) begin : g_chk_key
      $error("cam_slice: KEY_W must not exceed DATA_W");
   end
   if (PAGE_W + IDX_W > DATA_W) begin : g_chk_addr
      $error("cam_slice: page and index do not fit the data port");
   end

   cam_op_e            op;
   logic [PAGE_W-1:0]  page_q, dsel_q;
   logic               hit_q, multi_q;
   logic [IDX_W-1:0]   hidx_q;
   logic               oe_q;
   logic [DATA_W-1:0]  rdat_q;

   logic [ENTRIES-1:0] vld, hitv;
   logic [KEY_W-1:0]   ent_key;
   logic               cmp_any, cmp_multi, free_any, free_multi;
   logic [IDX_W-1:0]   cmp_idx, free_idx;
   logic               selected, winner, free_ok;
   logic               wr_en, clr_en;
   logic [IDX_W-1:0]   wr_idx;

   assign op       = cam_op_e'(cmd_op);
   assign selected = (dsel_q == page_q) || (dsel_q == '1);
   assign winner   = match_in_n && hit_q;
   assign free_ok  = !full_in_n && free_any;

   assign wr_en  = cmd_valid && ((op == OP_WRIDX && selected) ||
                                 (op == OP_WRFREE && free_ok));
   assign wr_idx = (op == OP_WRIDX) ? cmd_idx : free_idx;
   assign clr_en = cmd_valid && op == OP_INVAL && winner;

   cam_store #(.ENTRIES(ENTRIES), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_key  (cmd_data[KEY_W-1:0]),
      .clr_en  (clr_en),
      .clr_idx (hidx_q),
      .key     (cmd_data[KEY_W-1:0]),
      .rd_idx  (hidx_q),
      .rd_key  (ent_key),
      .vld     (vld),
      .hit     (hitv)
   );

   cam_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_hit_prio (
      .vec   (hitv),
      .any   (cmp_any),
      .multi (cmp_multi),
      .first (cmp_idx)
   );

   cam_prio #(.N(ENTRIES), .IDX_W(IDX_W)) u_free_prio (
      .vec   (~vld),
      .any   (free_any),
      .multi (free_multi),
      .first (free_idx)
   );

   function automatic logic [DATA_W-1:0] sys_addr(input logic [PAGE_W-1:0] pg,
                                                  input logic [IDX_W-1:0] ix);
      logic [DATA_W-1:0] w;
      w = '0;
      w[IDX_W +: PAGE_W] = pg;
      w[IDX_W-1:0]       = ix;
      return w;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page_q  <= '0;
         dsel_q  <= '1;
         hit_q   <= 1'b0;
         multi_q <= 1'b0;
         hidx_q  <= '0;
         oe_q    <= 1'b0;
         rdat_q  <= '0;
      end else begin
         oe_q   <= 1'b0;
         rdat_q <= '0;
         if (cmd_valid) begin
            case (op)
               OP_DSEL: dsel_q <= cmd_data[PAGE_W-1:0];
               OP_PAGE: if (selected) page_q <= cmd_data[PAGE_W-1:0];
               OP_CMP: begin
                  hit_q   <= cmp_any;
                  multi_q <= cmp_multi;
                  hidx_q  <= cmp_idx;
               end
               OP_INVAL: if (winner) begin
                  hit_q   <= 1'b0;
                  multi_q <= 1'b0;
               end
               OP_READ: begin
                  case (cmd_idx[1:0])
                     RK_STATUS: if (winner) begin
                        oe_q   <= 1'b1;
                        rdat_q <= sys_addr(page_q, hidx_q);
                     end
                     RK_FREE: if (free_ok) begin
                        oe_q   <= 1'b1;
                        rdat_q <= sys_addr(page_q, free_idx);
                     end
                     RK_ENTRY: if (winner) begin
                        oe_q   <= 1'b1;
                        rdat_q <= DATA_W'(ent_key);
                     end
                     default: ;
                  endcase
               end
               default: ;
            endcase
         end
      end
   end

   assign rd_oe   = oe_q;
   assign rd_data = rdat_q;
   assign ma_n    = !hit_q;
   assign mm_n    = !multi_q;
   assign mf_n    = match_in_n && !hit_q;
   assign ff_n    = full_in_n || free_any;
endmodule

// File: rtl/cam_slice_chk.sv
module cam_slice_chk
   import cam_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [2:0] cmd_op,
   input logic [1:0] cmd_kind,
   input logic       match_in_n,
   input logic       full_in_n,
   input logic       rd_oe,
   input logic       ma_n,
   input logic       mm_n,
   input logic       mf_n,
   input logic       ff_n
);
   p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ma_n && mm_n && !rd_oe));

   p_multi_needs_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mm_n |-> !ma_n);

   p_idle_no_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !rd_oe);

   p_earlier_match_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_READ && cmd_kind != RK_FREE && !match_in_n) |=> !rd_oe);

   p_chain_from_prev_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !match_in_n |-> !mf_n);

   p_chain_from_local_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ma_n |-> !mf_n);

   p_full_needs_prev_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ff_n |-> !full_in_n);

   p_free_read_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_READ && cmd_kind == RK_FREE && full_in_n) |=> !rd_oe);
endmodule

bind cam_slice cam_slice_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_op     (cmd_op),
   .cmd_kind   (cmd_idx[1:0]),
   .match_in_n (match_in_n),
   .full_in_n  (full_in_n),
   .rd_oe      (rd_oe),
   .ma_n       (ma_n),
   .mm_n       (mm_n),
   .mf_n       (mf_n),
   .ff_n       (ff_n)
);

// File: tb/sim_cam_slice.sv
`timescale 1ns/1ps
module sim_cam_slice;
   localparam int N  = 16;
   localparam int IW = 4;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          cmd_valid;
   logic [2:0]    cmd_op;
   logic [IW-1:0] cmd_idx;
   logic [DW-1:0] cmd_data;
   logic          match_in_n, full_in_n;
   logic [DW-1:0] rd_data;
   logic          rd_oe, ma_n, mm_n, mf_n, ff_n;

   always #2 clk = ~clk;

   cam_slice u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_idx(cmd_idx), .cmd_data(cmd_data), .match_in_n(match_in_n),
      .full_in_n(full_in_n), .rd_data(rd_data), .rd_oe(rd_oe),
      .ma_n(ma_n), .mm_n(mm_n), .mf_n(mf_n), .ff_n(ff_n)
   );

   // behavioural reference state
   logic [31:0] m_key [N];
   bit          m_vld [N];
   int          m_page, m_dsel, m_hidx;
   bit          m_hit, m_multi, m_oe;
   logic [31:0] m_rdat;

   int  vectors = 0;
   int  miscompares = 0;
   bit  finished = 0;

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic int free_idx();
      for (int i = 0; i < N; i++) if (!m_vld[i]) return i;
      return -1;
   endfunction

   task automatic compare_all(input string tag);
      int f;
      bit full;
      vectors++;
      f = free_idx();
      full = (f < 0);
      check(tag, "rd_oe", {31'd0, rd_oe}, {31'd0, m_oe});
      check(tag, "rd_data", rd_data, m_rdat);
      check((tag == "R1") ? "R1" : "R2", "ma_n", {31'd0, ma_n}, {31'd0, !m_hit});
      check((tag == "R1") ? "R1" : "R2", "mm_n", {31'd0, mm_n}, {31'd0, !m_multi});
      check("R5", "mf_n", {31'd0, mf_n}, {31'd0, match_in_n & !m_hit});
      check("R6", "ff_n", {31'd0, ff_n}, {31'd0, full_in_n | !full});
   endtask

   task automatic model_reset();
      for (int i = 0; i < N; i++) begin m_vld[i] = 0; m_key[i] = '0; end
      m_page = 0; m_dsel = 16'hFFFF; m_hidx = 0;
      m_hit = 0; m_multi = 0; m_oe = 0; m_rdat = '0;
   endtask

   task automatic step(input bit v, input int op, input int idx,
                       input logic [31:0] data, input bit mi, input bit fi);
      bit    sel, win, nfok;
      int    f, cnt, first;
      string tag;
      @(negedge clk);
      cmd_valid = v; cmd_op = op[2:0]; cmd_idx = idx[IW-1:0];
      cmd_data = data; match_in_n = mi; full_in_n = fi;
      @(posedge clk);
      sel  = (m_dsel == m_page) || (m_dsel == 16'hFFFF);
      win  = mi && m_hit;
      f    = free_idx();
      nfok = !fi && (f >= 0);
      m_oe = 0; m_rdat = '0;
      tag  = "R3";
      if (v) begin
         case (op)
            1: begin m_dsel = int'(data[15:0]); tag = "R9"; end
            2: begin if (sel) m_page = int'(data[15:0]); tag = "R9"; end
            3: begin
               cnt = 0; first = 0;
               for (int i = N - 1; i >= 0; i--)
                  if (m_vld[i] && m_key[i] == data) begin cnt++; first = i; end
               m_hit = cnt > 0; m_multi = cnt > 1;
               m_hidx = first; tag = "R2";
            end
            4: begin if (sel) begin m_key[idx] = data; m_vld[idx] = 1; end tag = "R9"; end
            5: begin if (nfok) begin m_key[f] = data; m_vld[f] = 1; end tag = "R7"; end
            6: begin
               case (idx & 3)
                  0: begin tag = win ? "R3" : "R4";
                     if (win) begin m_oe = 1; m_rdat = (m_page << IW) | m_hidx; end end
                  1: begin tag = "R8";
                     if (nfok) begin m_oe = 1; m_rdat = (m_page << IW) | f; end end
                  2: begin tag = win ? "R10" : "R4";
                     if (win) begin m_oe = 1; m_rdat = m_key[m_hidx]; end end
                  default: tag = "R3";
               endcase
            end
            7: begin
               if (win) begin m_vld[m_hidx] = 0; m_hit = 0; m_multi = 0; end
               tag = "R11";
            end
            default: tag = "R3";
         endcase
      end
      #1;
      compare_all(tag);
   endtask

   localparam logic [31:0] KA = 32'hA5A5_0001;
   localparam logic [31:0] KB = 32'h1234_5678;
   localparam logic [31:0] KM = 32'hDEAD_BEEF;

   initial begin
      rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_idx = 0; cmd_data = 0;
      match_in_n = 1; full_in_n = 0;
      model_reset();
      // R1 / R12: reset state
      repeat (3) begin
         @(posedge clk); #1; compare_all("R1");
      end
      @(negedge clk); rst_n = 1;
      step(0, 0, 0, 0, 1, 0);
      // R12: default select reaches this slice, page 0 reported
      step(1, 4, 3, KA, 1, 0);
      step(1, 3, 0, KA, 1, 0);          // R2 single match at 3
      step(1, 6, 0, 0, 1, 0);           // R3 status {0,3}
      step(1, 2, 0, 32'h5, 1, 0);       // R9 page load via broadcast
      step(1, 6, 0, 0, 1, 0);           // R3 status {5,3}
      // R9: select another slice, targeted writes ignored
      step(1, 1, 0, 32'h7, 1, 0);
      step(1, 4, 0, KA, 1, 0);
      step(1, 2, 0, 32'h9, 1, 0);
      step(1, 3, 0, KA, 1, 0);          // still single match
      step(1, 6, 0, 0, 1, 0);           // page still 5
      // R9 targeted by own page
      step(1, 1, 0, 32'h5, 1, 0);
      step(1, 4, 1, KA, 1, 0);
      step(1, 3, 0, KA, 1, 0);          // R2 multiple, index 1
      step(1, 6, 0, 0, 1, 0);
      step(1, 6, 2, 0, 1, 0);           // R10 entry read
      // R4/R5: earlier slice matched
      step(1, 6, 0, 0, 0, 0);
      step(1, 6, 2, 0, 0, 0);
      step(1, 7, 0, 0, 0, 0);           // R11 non-winner ignores
      step(1, 3, 0, KA, 1, 0);
      // miss: R4 refused, R8 next-free still served
      step(1, 3, 0, KM, 1, 0);
      step(1, 6, 0, 0, 1, 0);
      step(1, 6, 1, 0, 1, 0);
      step(1, 6, 1, 0, 1, 1);           // R8 refused with full_in_n high
      // R7: next-free writes with chain not full are ignored
      step(1, 5, 0, KB, 1, 1);
      step(1, 3, 0, KB, 1, 0);
      // R7/R6: fill the slice
      for (int i = 0; i < N; i++) step(1, 5, 0, 32'h100 + i, 1, 0);
      step(0, 0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 1, 1);           // R6 ff_n follows full_in_n
      step(1, 5, 0, KB, 1, 0);          // ignored, slice full
      step(1, 3, 0, KB, 1, 0);
      step(1, 6, 1, 0, 1, 0);           // R8 full, refused
      // R11: invalidate winner, then the freed slot is next free
      step(1, 3, 0, 32'h100, 1, 0);
      step(1, 6, 2, 0, 1, 0);
      step(1, 7, 0, 0, 1, 0);
      step(1, 6, 1, 0, 1, 0);
      step(1, 3, 0, KA, 1, 0);
      step(1, 7, 0, 0, 1, 0);
      step(1, 3, 0, KA, 1, 0);
      // random mixture
      for (int n = 0; n < 1500; n++) begin
         int op, ix, ksel, d;
         op   = $urandom_range(0, 7);
         ix   = $urandom_range(0, N - 1);
         ksel = $urandom_range(0, 3);
         d    = (ksel == 0) ? KA : (ksel == 1) ? KB : (ksel == 2) ? KM : 32'h100 + ix;
         if (op == 1) d = ($urandom_range(0, 2) == 0) ? 32'hFFFF : $urandom_range(4, 6);
         if (op == 2) d = $urandom_range(4, 6);
         step($urandom_range(0, 7) != 0, op, ix, d,
              $urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0);
      end
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule